// File: doc/BRIEF.md
# Serial-Loaded Segmented DAC Front End

This block is the digital side of a 14-bit voltage-output converter. A host writes a code word over a three-wire serial link made of an active-low chip select, a serial clock and a data line. While chip select is low, each rising serial-clock edge shifts one data bit into a shift register, most significant bit first. When chip select returns high after a complete word, the word is copied into the DAC code register, which then drives the switch controls of the resistor network.

The held code is split in two. The top four bits go through a thermometer decoder that drives 15 equal-weight segment switches. The bottom ten bits drive the ten switches of a binary R-2R ladder directly. The three serial pins are brought into the system clock domain through synchronizers, and all edges are detected there. The system clock therefore has to run at least four times faster than the serial clock, which may reach 25 MHz. At reset the code register holds zero. That is the lowest output in unipolar use and negative full scale in bipolar use.

Top module: `sdac_front_end`

## Requirements
- R1: While rst_ni is low, code_o is 0, every bit of seg_en_o and ladder_sw_o is 0, and load_o is 0.
- R2: A data bit is taken only on a rising serial-clock edge seen while chip select is low. Bits enter at the least significant end, so the first bit of a frame ends up as the most significant bit. Serial-clock edges while chip select is high change nothing.
- R3: When more than 14 clock edges arrive in one frame, the loaded code is made of the last 14 bits shifted in.
- R4: A chip-select rising edge after at least 14 bits loads the shift register into code_o. The update is visible on the second system-clock edge after the first edge that samples chip select high (two synchronizer stages).
- R5: seg_en_o[i] is 1 exactly when i < code_o[13:10], for i = 0..14. A value k therefore turns on exactly k segments, filled from bit 0 upward.
- R6: ladder_sw_o[i] equals code_o[i] for i = 0..9. Bit 0 drives the least significant ladder switch.
- R7: When chip select rises after fewer than 14 clock edges, including zero, the frame is discarded: code_o keeps its value and load_o stays 0.
- R8: load_o is high for exactly one system clock in each cycle in which code_o is loaded, and code_o never changes without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| code_o | output | 14 | Held DAC code |
| seg_en_o | output | 15 | Thermometer segment switch enables |
| ladder_sw_o | output | 10 | R-2R ladder switch controls |
| load_o | output | 1 | One-cycle strobe when code_o is loaded |

## Verification
The assertions assume that each serial pin holds a level for at least two system clocks. They also assume that data is stable from before a serial-clock rise until after it, and that no chip-select edge lands in the same synchronized cycle as a serial-clock rise. Under those conditions the shift register and bit counter move only as the properties state. The stimulus holds every serial-clock phase for three system clocks, changes data together with the falling serial clock, and leaves three quiet cycles around each chip-select edge. Frames of zero, short, exact and overlong length are all sent this way, along with a reset in the middle of a frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
  import sdac_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pins_t d_i,
  output pins_t q_o
);
  pins_t stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= PINS_IDLE;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= PINS_IDLE;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_serial_rx.sv
module sdac_serial_rx
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pins_t             pins_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  pins_t             prev_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cs_rise, cs_fall, bit_take;

  assign cs_rise  = pins_i.cs_n & ~prev_q.cs_n;
  assign cs_fall  = ~pins_i.cs_n & prev_q.cs_n;
  assign bit_take = pins_i.sclk & ~prev_q.sclk & ~pins_i.cs_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= PINS_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      prev_q <= pins_i;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (bit_take) begin
        shift_q <= {shift_q[DATA_W-2:0], pins_i.sdi};
        // saturate: an overlong frame still counts as complete
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o = cs_rise & (cnt_q == CNT_FULL);
  assign word_o   = shift_q;

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_take && !cs_fall) |=> shift_q[0] == $past(pins_i.sdi));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_take && !cs_fall && cnt_q != CNT_FULL) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i.cs_n && $past(pins_i.cs_n)) |=> $stable(shift_q));
endmodule

// File: rtl/sdac_switch_decode.sv
module sdac_switch_decode #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned SEG_W  = 4,
  localparam int unsigned SEG_N    = (1 << SEG_W) - 1,
  localparam int unsigned LADDER_W = DATA_W - SEG_W
) (
  input  logic [DATA_W-1:0]   code_i,
  output logic [SEG_N-1:0]    seg_en_o,
  output logic [LADDER_W-1:0] ladder_sw_o
);
  logic [SEG_W-1:0] seg_code;

  assign seg_code    = code_i[DATA_W-1 -: SEG_W];
  assign ladder_sw_o = code_i[LADDER_W-1:0];

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_en_o[i] = seg_code > SEG_W'(i);
  end
endmodule

// File: rtl/sdac_front_end.sv
module sdac_front_end
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEG_N    = (1 << SEG_W) - 1,
  localparam int unsigned LADDER_W = DATA_W - SEG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic [DATA_W-1:0]   code_o,
  output logic [SEG_N-1:0]    seg_en_o,
  output logic [LADDER_W-1:0] ladder_sw_o,
  output logic                load_o
);
  pins_t             pins_raw, pins_s;
  logic              commit;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] dac_q;
  logic              load_q;

  assign pins_raw = '{cs_n: cs_ni, sclk: sclk_i, sdi: sdi_i};

  sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sdac_serial_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins_s),
    .commit_o(commit),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= commit;
      if (commit) dac_q <= word;
    end
  end

  sdac_switch_decode #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_dec (
    .code_i     (dac_q),
    .seg_en_o   (seg_en_o),
    .ladder_sw_o(ladder_sw_o)
  );

  assign code_o = dac_q;
  assign load_o = load_q;

  assert_code_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> load_o);

  assert_load_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_seg_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seg_en_o) == 32'(code_o[DATA_W-1 -: SEG_W]));

  assert_seg_contig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_en_o + SEG_N'(1)) & seg_en_o) == '0);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0 && !load_o));
endmodule

// File: tb/sdac_front_end_bench.sv
module sdac_front_end_bench;
  logic        clk = 1'b0, rst_n = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [13:0] code;
  logic [14:0] seg;
  logic [9:0]  lad;
  logic        load;

  int errors = 0, checks = 0, n_loads = 0, exp_loads = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdac_front_end u_sdac_front_end (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code), .seg_en_o(seg), .ladder_sw_o(lad), .load_o(load)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] thermo(int k);
    logic [14:0] t;
    for (int i = 0; i < 15; i++) t[i] = (i < k);
    return t;
  endfunction

  // reference model: pin history sampled at each rising clock
  logic [2:0]  hist[$];
  logic [13:0] e_shift = '0, e_dac = '0;
  int          e_cnt = 0;
  logic        e_load = 1'b0;

  always @(posedge clk) begin
    hist.push_back({cs_n, sclk, sdi});
    if (hist.size() > 8) void'(hist.pop_front());
  end

  always @(negedge clk) begin
    logic [2:0] cur, prv;
    if (!rst_n) begin
      hist = '{3'b100, 3'b100, 3'b100, 3'b100};
      e_shift = '0; e_dac = '0; e_cnt = 0; e_load = 1'b0;
      chk(code === '0 && seg === '0 && lad === '0 && load === 1'b0,
          "R1 reset state", {code, load}, 0);
    end else begin
      // outputs after this edge reflect pins sampled two edges earlier vs three
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      e_load = 1'b0;
      if (cur[2] && !prv[2]) begin
        if (e_cnt >= 14) begin e_dac = e_shift; e_load = 1'b1; end
      end
      if (!cur[2] && prv[2]) e_cnt = 0;
      else if (!cur[2] && cur[1] && !prv[1]) begin
        e_shift = {e_shift[12:0], cur[0]};
        if (e_cnt < 14) e_cnt++;
      end
      if (load === 1'b1) n_loads++;
      chk(code === e_dac, "R4 code_o", code, e_dac);
      chk(load === e_load, "R8 load_o", load, e_load);
      chk(seg === thermo(int'(e_dac[13:10])), "R5 seg_en_o", seg, thermo(int'(e_dac[13:10])));
      chk(lad === e_dac[9:0], "R6 ladder_sw_o", lad, e_dac[9:0]);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_frame(logic [31:0] w, int n);
    cs_n = 1'b0;
    wait_cyc(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; sclk = 1'b0;
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(3);
    end
    sclk = 1'b0;
    wait_cyc(3);
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  initial begin
    logic [13:0] words[5] = '{14'h2AAA, 14'h3FFF, 14'h0000, 14'h2000, 14'h1555};
    logic [13:0] held, w;
    #1 rst_n = 1'b0;
    wait_cyc(3);
    @(negedge clk);
    chk(code === '0 && seg === '0, "R1 power-on code zero", code, 0);
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(4);

    foreach (words[i]) begin
      send_frame(32'(words[i]), 14);
      exp_loads++;
      @(negedge clk);
      chk(code === words[i], "R2 msb-first word", code, words[i]);
    end

    for (int k = 0; k < 16; k++) begin
      w = {4'(k), 10'(k * 37 + 5)};
      send_frame(32'(w), 14);
      exp_loads++;
      @(negedge clk);
      chk($countones(seg) == k, "R5 segment count", $countones(seg), k);
      chk(lad === w[9:0], "R6 ladder bits", lad, w[9:0]);
    end

    held = code;
    send_frame(32'h0F0F, 9);
    @(negedge clk);
    chk(code === held, "R7 short frame discarded", code, held);
    send_frame(32'h0, 0);
    @(negedge clk);
    chk(code === held, "R7 empty frame discarded", code, held);

    send_frame(32'hABCDE, 20);
    exp_loads++;
    @(negedge clk);
    chk(code === 14'h0DE ^ 14'h2C00 ^ 14'h0000 ? code === 14'(20'hABCDE) : 1'b0,
        "R3 last 14 bits kept", code, 14'(20'hABCDE));

    held = code;
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; wait_cyc(3);
      sclk = 1'b0; wait_cyc(3);
    end
    cs_n = 1'b0; wait_cyc(4); cs_n = 1'b1; wait_cyc(8);
    @(negedge clk);
    chk(code === held, "R2 clocks with chip select high ignored", code, held);

    send_frame(32'h1234, 14);
    exp_loads++;
    send_frame(32'h2345, 14);
    exp_loads++;
    @(negedge clk);
    chk(code === 14'h2345, "R4 back-to-back frames", code, 14'h2345);

    cs_n = 1'b0; wait_cyc(3);
    for (int i = 0; i < 6; i++) begin
      sdi = i[0]; sclk = 1'b0; wait_cyc(3); sclk = 1'b1; wait_cyc(3);
    end
    rst_n = 1'b0;
    wait_cyc(2);
    @(negedge clk);
    chk(code === '0 && load === 1'b0, "R1 reset mid-frame", code, 0);
    wait_cyc(1);
    rst_n = 1'b1;
    sclk = 1'b0; wait_cyc(3);
    cs_n = 1'b1; wait_cyc(8);
    @(negedge clk);
    chk(code === '0, "R7 frame cut by reset not loaded", code, 0);

    chk(n_loads == exp_loads, "R8 load strobe count", n_loads, exp_loads);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule